// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steers a processor from an ordinary instruction boundary into an exception service routine. It watches three request sources: a trap request from the core's execution logic, which carries its own vector; a non-maskable interrupt line; and a maskable interrupt line. At an instruction boundary it picks one request, takes a copy of the status word and forces the live status word into supervisor mode on the interrupt stack. It then obtains a vector and calls the service routine through a table of procedure descriptors.

Vector sources differ by kind. A trap supplies its own vector. The non-maskable interrupt uses a fixed default vector. A maskable interrupt fetches its vector from the data bus through an acknowledge handshake. The vector selects a 32-bit descriptor in a table that starts at the interrupt base address. The low half of the descriptor is the new module value. The module value points at a program base word, and the high half of the descriptor is an offset from that base. Before the block hands the new program counter back to the core, it pushes the old status, module and program counter onto the interrupt stack over a single request/acknowledge memory port.

States: `ST_IDLE` (waiting), `ST_ADJUST` (status copy and forcing), `ST_IACK` (bus vector fetch), `ST_DESC` (descriptor read), `ST_PBASE` (program base read), `ST_PUSH_SW` (status/module push), `ST_PUSH_PC` (program counter push), `ST_FINISH` (result valid). Transitions: IDLE→ADJUST on an accepted request; ADJUST→IACK for a maskable interrupt, otherwise ADJUST→DESC; IACK→DESC on `iack_done`; DESC→PBASE, PBASE→PUSH_SW, PUSH_SW→PUSH_PC and PUSH_PC→FINISH, each on `mem_ack`; FINISH→IDLE unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `busy`, `done`, `psr_wr`, `mem_req` and `iack_req` are all 0.
- R2: A request is accepted only at a clock edge where the block is idle and `boundary` is 1. Priority runs trap, then non-maskable interrupt, then maskable interrupt. The maskable interrupt is accepted only when bit 11 of `psr_in` is 1. While busy, `exc_kind` reports 1 for a trap, 2 for a non-maskable interrupt and 3 for a maskable interrupt, and it reports 0 when idle.
- R3: In the cycle after acceptance, `psr_wr` is 1 for exactly one cycle. `psr_out` then equals the captured `psr_in` with bit 8 (user mode) and bit 9 (user stack) cleared and every other bit unchanged.
- R4: A trap uses `trap_vec` as its vector and a non-maskable interrupt uses the parameter `NMI_VEC` (default 1). A maskable interrupt raises `iack_req`, holds it until `iack_done`, and uses `iack_data` as its vector.
- R5: The first memory access is a read (`mem_we`=0) at `intbase_in` + 4 × vector, and it returns the descriptor.
- R6: The second memory access is a read at the zero-extended descriptor bits [15:0] plus `PB_OFS` (default 8), and it returns the program base.
- R7: The third access writes {status copy, `mod_in`} to `isp_in`−4, with the status copy in bits [31:16]. The fourth writes `pc_in` to `isp_in`−8. During `done`, `isp_out` equals `isp_in`−8.
- R8: `done` lasts one cycle. During it, `new_mod` equals descriptor bits [15:0] and `new_pc` equals the program base plus the zero-extended descriptor bits [31:16]. `busy` is 0 in the cycle after `done`.
- R9: `busy` stays 1 from the cycle after acceptance through the `done` cycle. Requests and `boundary` have no effect while busy, so one accepted request produces exactly one status update and one result.
- R10: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`. `mem_req` and `iack_req` are never 1 together.
- R11: The phases run in a fixed order: status update, then vector acquisition, then descriptor read, program base read, the two pushes, and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary; requests may be taken |
| trap_req | input | 1 | Trap condition pending |
| trap_vec | input | VEC_W | Vector carried by the trap |
| nmi_req | input | 1 | Non-maskable interrupt request |
| int_req | input | 1 | Maskable interrupt request |
| psr_in | input | 16 | Live status word |
| mod_in | input | 16 | Current module register |
| pc_in | input | 32 | Program counter to save |
| isp_in | input | 32 | Interrupt stack pointer |
| intbase_in | input | 32 | Dispatch table base |
| iack_req | output | 1 | Interrupt acknowledge cycle request |
| iack_done | input | 1 | Acknowledge cycle complete, vector valid |
| iack_data | input | VEC_W | Vector from the data bus |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Entry sequence in progress |
| exc_kind | output | 2 | Kind of exception being entered |
| psr_wr | output | 1 | Load `psr_out` into the live status word |
| psr_out | output | 16 | Forced status word |
| done | output | 1 | New program counter valid |
| new_pc | output | 32 | Service routine program counter |
| new_mod | output | 16 | Service routine module value |
| isp_out | output | 32 | Interrupt stack pointer after pushes |

## Verification
A state register that skips or repeats a phase shows up at the memory port within a few cycles. An access goes missing, appears twice or lands at the wrong address, and the stack pointer returned with `done` stops being eight below the one given. A wrong captured kind or vector shows up in the descriptor read address, the first access after the status update. A wrong status copy shows in the word written by the first push. Ordering faults show as a status write that follows a memory access, or as `busy` dropping before `done`; each appears within the same sequence.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int WORD_W       = 32;
    localparam int HALF_W       = 16;
    localparam int PSR_USER_BIT = 8;
    localparam int PSR_USTK_BIT = 9;
    localparam int PSR_IEN_BIT  = 11;

    localparam logic [HALF_W-1:0] PSR_FORCE_CLR =
        HALF_W'((1 << PSR_USER_BIT) | (1 << PSR_USTK_BIT));

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADJUST,
        ST_IACK,
        ST_DESC,
        ST_PBASE,
        ST_PUSH_SW,
        ST_PUSH_PC,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_TRAP = 2'd1,
        KIND_NMI  = 2'd2,
        KIND_INT  = 2'd3
    } exc_kind_t;

endpackage

// File: rtl/exc_req_arb.sv
module exc_req_arb
    import exc_entry_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 1
) (
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             nmi_req,
    input  logic             int_req,
    input  logic             int_en,
    output logic             take,
    output exc_kind_t        kind,
    output logic [VEC_W-1:0] vec
);

    localparam logic [VEC_W-1:0] NMI_VEC_L = VEC_W'(NMI_VEC);

    // Fixed priority: trap over non-maskable over maskable interrupt.
    always_comb begin
        take = 1'b0;
        kind = KIND_NONE;
        vec  = '0;
        if (trap_req) begin
            take = 1'b1;
            kind = KIND_TRAP;
            vec  = trap_vec;
        end else if (nmi_req) begin
            take = 1'b1;
            kind = KIND_NMI;
            vec  = NMI_VEC_L;
        end else if (int_req && int_en) begin
            take = 1'b1;
            kind = KIND_INT;
            vec  = '0;      // replaced by the bus vector later
        end
    end

endmodule

// File: rtl/exc_bus_mux.sv
module exc_bus_mux
    import exc_entry_pkg::*;
#(
    parameter int               VEC_W  = 8,
    parameter logic [WORD_W-1:0] PB_OFS = 32'd8
) (
    input  seq_state_t         state,
    input  logic [VEC_W-1:0]   vec_q,
    input  logic [WORD_W-1:0]  intbase_q,
    input  logic [WORD_W-1:0]  desc_q,
    input  logic [WORD_W-1:0]  sp_q,
    input  logic [HALF_W-1:0]  saved_psr,
    input  logic [HALF_W-1:0]  saved_mod,
    input  logic [WORD_W-1:0]  saved_pc,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               iack_req
);

    localparam int PAD_W = WORD_W - VEC_W - 2;

    logic [WORD_W-1:0] tab_off;
    logic [WORD_W-1:0] push_addr;

    // Table entries are one word each: offset is vector times four.
    generate
        if (PAD_W > 0) begin : g_pad
            assign tab_off = {{PAD_W{1'b0}}, vec_q, 2'b00};
        end else begin : g_nopad
            assign tab_off = WORD_W'({vec_q, 2'b00});
        end
    endgenerate

    // Pre-decrement push.
    assign push_addr = sp_q - WORD_W'(4);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        iack_req  = 1'b0;
        unique case (state)
            ST_IACK: begin
                iack_req = 1'b1;
            end
            ST_DESC: begin
                mem_req  = 1'b1;
                mem_addr = intbase_q + tab_off;
            end
            ST_PBASE: begin
                mem_req  = 1'b1;
                mem_addr = {{(WORD_W-HALF_W){1'b0}}, desc_q[HALF_W-1:0]} + PB_OFS;
            end
            ST_PUSH_SW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = {saved_psr, saved_mod};
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = saved_pc;
            end
            ST_IDLE, ST_ADJUST, ST_FINISH: begin
                mem_req = 1'b0;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary,
    input  logic               arb_take,
    input  exc_kind_t          arb_kind,
    input  logic [VEC_W-1:0]   arb_vec,
    input  logic [HALF_W-1:0]  psr_in,
    input  logic [HALF_W-1:0]  mod_in,
    input  logic [WORD_W-1:0]  pc_in,
    input  logic [WORD_W-1:0]  isp_in,
    input  logic [WORD_W-1:0]  intbase_in,
    input  logic               iack_done,
    input  logic [VEC_W-1:0]   iack_data,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output seq_state_t         state,
    output logic [VEC_W-1:0]   vec_q,
    output logic [WORD_W-1:0]  intbase_q,
    output logic [WORD_W-1:0]  desc_q,
    output logic [WORD_W-1:0]  sp_q,
    output logic [HALF_W-1:0]  saved_psr,
    output logic [HALF_W-1:0]  saved_mod,
    output logic [WORD_W-1:0]  saved_pc,
    output logic               busy,
    output exc_kind_t          exc_kind,
    output logic               psr_wr,
    output logic [HALF_W-1:0]  psr_out,
    output logic               done,
    output logic [WORD_W-1:0]  new_pc,
    output logic [HALF_W-1:0]  new_mod,
    output logic [WORD_W-1:0]  isp_out
);

    seq_state_t        st_q, st_d;
    exc_kind_t         kind_q;
    logic [WORD_W-1:0] pbase_q;
    logic              accept;

    assign accept = (st_q == ST_IDLE) && boundary && arb_take;
    assign state  = st_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (accept)    st_d = ST_ADJUST;
            ST_ADJUST:  st_d = (kind_q == KIND_INT) ? ST_IACK : ST_DESC;
            ST_IACK:    if (iack_done) st_d = ST_DESC;
            ST_DESC:    if (mem_ack)   st_d = ST_PBASE;
            ST_PBASE:   if (mem_ack)   st_d = ST_PUSH_SW;
            ST_PUSH_SW: if (mem_ack)   st_d = ST_PUSH_PC;
            ST_PUSH_PC: if (mem_ack)   st_d = ST_FINISH;
            ST_FINISH:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Context and fetched data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= KIND_NONE;
            vec_q     <= '0;
            intbase_q <= '0;
            desc_q    <= '0;
            pbase_q   <= '0;
            sp_q      <= '0;
            saved_psr <= '0;
            saved_mod <= '0;
            saved_pc  <= '0;
        end else begin
            if (accept) begin
                kind_q    <= arb_kind;
                vec_q     <= arb_vec;
                intbase_q <= intbase_in;
                sp_q      <= isp_in;
                saved_psr <= psr_in;
                saved_mod <= mod_in;
                saved_pc  <= pc_in;
            end
            if (st_q == ST_IACK && iack_done) begin
                vec_q <= iack_data;
            end
            if (st_q == ST_DESC && mem_ack) begin
                desc_q <= mem_rdata;
            end
            if (st_q == ST_PBASE && mem_ack) begin
                pbase_q <= mem_rdata;
            end
            if ((st_q == ST_PUSH_SW || st_q == ST_PUSH_PC) && mem_ack) begin
                sp_q <= sp_q - WORD_W'(4);
            end
        end
    end

    // Outputs by state.
    always_comb begin
        busy     = 1'b1;
        exc_kind = kind_q;
        psr_wr   = 1'b0;
        psr_out  = '0;
        done     = 1'b0;
        new_pc   = '0;
        new_mod  = '0;
        isp_out  = '0;
        unique case (st_q)
            ST_IDLE: begin
                busy     = 1'b0;
                exc_kind = KIND_NONE;
            end
            ST_ADJUST: begin
                psr_wr  = 1'b1;
                psr_out = saved_psr & ~PSR_FORCE_CLR;
            end
            ST_FINISH: begin
                done    = 1'b1;
                new_mod = desc_q[HALF_W-1:0];
                new_pc  = pbase_q
                        + {{(WORD_W-HALF_W){1'b0}}, desc_q[WORD_W-1:HALF_W]};
                isp_out = sp_q;
            end
            ST_IACK, ST_DESC, ST_PBASE, ST_PUSH_SW, ST_PUSH_PC: begin
                busy = 1'b1;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int          VEC_W   = 8,
    parameter int          NMI_VEC = 1,
    parameter logic [31:0] PB_OFS  = 32'd8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             nmi_req,
    input  logic             int_req,
    input  logic [15:0]      psr_in,
    input  logic [15:0]      mod_in,
    input  logic [31:0]      pc_in,
    input  logic [31:0]      isp_in,
    input  logic [31:0]      intbase_in,
    output logic             iack_req,
    input  logic             iack_done,
    input  logic [VEC_W-1:0] iack_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic [1:0]       exc_kind,
    output logic             psr_wr,
    output logic [15:0]      psr_out,
    output logic             done,
    output logic [31:0]      new_pc,
    output logic [15:0]      new_mod,
    output logic [31:0]      isp_out
);

    logic              arb_take;
    exc_kind_t         arb_kind;
    logic [VEC_W-1:0]  arb_vec;
    seq_state_t        state;
    logic [VEC_W-1:0]  vec_q;
    logic [WORD_W-1:0] intbase_q, desc_q, sp_q, saved_pc;
    logic [HALF_W-1:0] saved_psr, saved_mod;
    exc_kind_t         kind_w;

    exc_req_arb #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_arb (
        .trap_req (trap_req),
        .trap_vec (trap_vec),
        .nmi_req  (nmi_req),
        .int_req  (int_req),
        .int_en   (psr_in[PSR_IEN_BIT]),
        .take     (arb_take),
        .kind     (arb_kind),
        .vec      (arb_vec)
    );

    exc_entry_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .arb_take   (arb_take),
        .arb_kind   (arb_kind),
        .arb_vec    (arb_vec),
        .psr_in     (psr_in),
        .mod_in     (mod_in),
        .pc_in      (pc_in),
        .isp_in     (isp_in),
        .intbase_in (intbase_in),
        .iack_done  (iack_done),
        .iack_data  (iack_data),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .vec_q      (vec_q),
        .intbase_q  (intbase_q),
        .desc_q     (desc_q),
        .sp_q       (sp_q),
        .saved_psr  (saved_psr),
        .saved_mod  (saved_mod),
        .saved_pc   (saved_pc),
        .busy       (busy),
        .exc_kind   (kind_w),
        .psr_wr     (psr_wr),
        .psr_out    (psr_out),
        .done       (done),
        .new_pc     (new_pc),
        .new_mod    (new_mod),
        .isp_out    (isp_out)
    );

    exc_bus_mux #(.VEC_W(VEC_W), .PB_OFS(PB_OFS)) u_bus (
        .state     (state),
        .vec_q     (vec_q),
        .intbase_q (intbase_q),
        .desc_q    (desc_q),
        .sp_q      (sp_q),
        .saved_psr (saved_psr),
        .saved_mod (saved_mod),
        .saved_pc  (saved_pc),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .iack_req  (iack_req)
    );

    assign exc_kind = kind_w;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        boundary,
    input logic        busy,
    input logic [1:0]  exc_kind,
    input logic        psr_wr,
    input logic [15:0] psr_out,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        iack_req,
    input logic        iack_done
);

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !psr_wr && !mem_req && !iack_req);

    p_no_take_off_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !boundary |=> !busy);

    p_kind_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(exc_kind) && exc_kind != 2'd0);

    p_supervisor_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        psr_wr |-> !psr_out[PSR_USER_BIT] && !psr_out[PSR_USTK_BIT]);

    p_iack_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iack_req && !iack_done |=> iack_req);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_busy_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)
                                && $stable(mem_we) && $stable(mem_wdata));

    p_port_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && iack_req));

    p_status_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> psr_wr && !mem_req && !iack_req);

endmodule

bind exc_entry_seq exc_entry_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .busy      (busy),
    .exc_kind  (exc_kind),
    .psr_wr    (psr_wr),
    .psr_out   (psr_out),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .iack_req  (iack_req),
    .iack_done (iack_done)
);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_vec = '0;
    logic        nmi_req = 1'b0;
    logic        int_req = 1'b0;
    logic [15:0] psr_in = '0;
    logic [15:0] mod_in = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] isp_in = '0;
    logic [31:0] intbase_in = '0;
    logic        iack_req;
    logic        iack_done = 1'b0;
    logic [7:0]  iack_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, psr_wr, done;
    logic [1:0]  exc_kind;
    logic [15:0] psr_out, new_mod;
    logic [31:0] new_pc, isp_out;

    always #4 clk = ~clk;

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .trap_req(trap_req), .trap_vec(trap_vec), .nmi_req(nmi_req),
        .int_req(int_req), .psr_in(psr_in), .mod_in(mod_in), .pc_in(pc_in),
        .isp_in(isp_in), .intbase_in(intbase_in), .iack_req(iack_req),
        .iack_done(iack_done), .iack_data(iack_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
        .exc_kind(exc_kind), .psr_wr(psr_wr), .psr_out(psr_out), .done(done),
        .new_pc(new_pc), .new_mod(new_mod), .isp_out(isp_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] bus_vec = '0;

    // Logs written only by their own process.
    int          psr_n = 0;   logic [15:0] psr_v [0:511]; int psr_c [0:511];
    int          done_n = 0;  int done_c [0:511]; logic [1:0] done_k [0:511];
    logic [31:0] done_pc [0:511]; logic [15:0] done_mod [0:511]; logic [31:0] done_isp [0:511];
    int          gap = 0;
    int          iack_n = 0;  int iack_c [0:511];
    int          mem_n = 0;   int mem_c [0:511]; logic mem_w [0:511];
    logic [31:0] mem_a [0:511]; logic [31:0] mem_d [0:511];

    function automatic logic [31:0] memval(input logic [31:0] a);
        return ((a ^ 32'h5A17_C3E9) * 32'd2654435761) + 32'h0000_1357;
    endfunction

    always @(posedge clk) cyc = cyc + 1;

    // Output monitor.
    logic prev_busy = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (psr_wr) begin
                psr_v[psr_n] = psr_out; psr_c[psr_n] = cyc; psr_n = psr_n + 1;
            end
            if (done) begin
                done_c[done_n] = cyc; done_k[done_n] = exc_kind;
                done_pc[done_n] = new_pc; done_mod[done_n] = new_mod;
                done_isp[done_n] = isp_out; done_n = done_n + 1;
            end
            if (prev_busy && !prev_done && !busy) gap = gap + 1;
            prev_busy = busy;
            prev_done = done;
        end
    end

    // Memory responder with random wait.
    int mwait = -1;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; mwait = -1;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mwait < 0) mwait = int'($urandom % 4);
            if (mwait == 0) begin
                mem_ack = 1'b1;
                mem_rdata = mem_we ? 32'h0 : memval(mem_addr);
                mem_a[mem_n] = mem_addr; mem_w[mem_n] = mem_we;
                mem_d[mem_n] = mem_wdata; mem_c[mem_n] = cyc;
                mem_n = mem_n + 1;
                mwait = -1;
            end else begin
                mwait = mwait - 1;
            end
        end
    end

    // Interrupt acknowledge responder.
    int iwait = -1;
    always @(negedge clk) begin
        if (!rst_n) begin
            iack_done = 1'b0; iwait = -1;
        end else if (iack_done) begin
            iack_done = 1'b0;
        end else if (iack_req) begin
            if (iwait < 0) iwait = int'($urandom % 3);
            if (iwait == 0) begin
                iack_done = 1'b1; iack_data = bus_vec;
                iack_c[iack_n] = cyc; iack_n = iack_n + 1;
                iwait = -1;
            end else begin
                iwait = iwait - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drop_reqs();
        trap_req = 1'b0; nmi_req = 1'b0; int_req = 1'b0; boundary = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk(k < 300, "R9 sequence completes", 32'(k), 32'd300);
    endtask

    task automatic run_case(input bit t, input bit n, input bit i, input bit ien,
                            input logic [7:0] tv, input logic [7:0] iv,
                            input logic [31:0] ib, input logic [31:0] isp,
                            input logic [31:0] pc, input logic [15:0] pbase,
                            input logic [15:0] mod);
        logic [15:0] psr;
        logic [7:0]  vec;
        logic [1:0]  kind;
        logic [31:0] da, desc, pa, pb;
        bit          take;
        int p0, m0, d0, i0, g0;
        psr  = ien ? (pbase | 16'h0800) : (pbase & ~16'h0800);
        take = t || n || (i && ien);
        kind = t ? 2'd1 : (n ? 2'd2 : 2'd3);
        vec  = t ? tv : (n ? 8'd1 : iv);
        da   = ib + {22'd0, vec, 2'b00};
        desc = memval(da);
        pa   = {16'd0, desc[15:0]} + 32'd8;
        pb   = memval(pa);
        p0 = psr_n; m0 = mem_n; d0 = done_n; i0 = iack_n; g0 = gap;
        trap_req = t; nmi_req = n; int_req = i; trap_vec = tv; bus_vec = iv;
        psr_in = psr; mod_in = mod; pc_in = pc; isp_in = isp; intbase_in = ib;
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        if (!take) begin
            repeat (3) begin
                @(negedge clk);
                chk(!busy, "R2 masked interrupt ignored", 32'(busy), 32'd0);
            end
            #1;
            chk(psr_n == p0, "R2 no status update", 32'(psr_n - p0), 32'd0);
            drop_reqs();
            return;
        end
        wait_done();
        drop_reqs();
        @(negedge clk);
        chk(!busy, "R8 idle after done", 32'(busy), 32'd0);
        #1;
        chk(done_k[d0] == kind, "R2 priority kind", 32'(done_k[d0]), 32'(kind));
        chk(psr_n == p0 + 1 && psr_v[p0] == (psr & 16'hFCFF), "R3 forced status",
            {16'(psr_n - p0), psr_v[p0]}, {16'd1, psr & 16'hFCFF});
        chk((iack_n - i0) == ((kind == 2'd3) ? 1 : 0), "R4 acknowledge count",
            32'(iack_n - i0), 32'(kind == 2'd3));
        chk(mem_n == m0 + 4, "R11 access count", 32'(mem_n - m0), 32'd4);
        chk(!mem_w[m0] && mem_a[m0] == da, "R5 descriptor address", mem_a[m0], da);
        chk(!mem_w[m0+1] && mem_a[m0+1] == pa, "R6 program base address", mem_a[m0+1], pa);
        chk(mem_w[m0+2] && mem_a[m0+2] == isp - 32'd4 && mem_d[m0+2] == {psr, mod},
            "R7 status push", mem_d[m0+2], {psr, mod});
        chk(mem_w[m0+3] && mem_a[m0+3] == isp - 32'd8 && mem_d[m0+3] == pc,
            "R7 pc push", mem_a[m0+3], isp - 32'd8);
        chk(done_isp[d0] == isp - 32'd8, "R7 stack out", done_isp[d0], isp - 32'd8);
        chk(done_mod[d0] == desc[15:0], "R8 new module", 32'(done_mod[d0]), 32'(desc[15:0]));
        chk(done_pc[d0] == pb + {16'd0, desc[31:16]}, "R8 new pc",
            done_pc[d0], pb + {16'd0, desc[31:16]});
        chk(done_n == d0 + 1 && gap == g0, "R9 busy continuous", 32'(gap - g0), 32'd0);
        chk(psr_c[p0] < mem_c[m0] && mem_c[m0] < mem_c[m0+1] && mem_c[m0+1] < mem_c[m0+2]
            && mem_c[m0+2] < mem_c[m0+3] && mem_c[m0+3] < done_c[d0]
            && (kind != 2'd3 || (psr_c[p0] < iack_c[i0] && iack_c[i0] < mem_c[m0])),
            "R11 phase order", 32'(psr_c[p0]), 32'(mem_c[m0]));
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !psr_wr && !mem_req && !iack_req, "R1 reset outputs",
            {27'd0, busy, done, psr_wr, mem_req, iack_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 first cycle idle", {30'd0, busy, mem_req}, 32'd0);

        // Directed corners: priority and masking.
        run_case(1, 1, 1, 1, 8'h05, 8'h21, 32'h0000_1000, 32'h0000_8000, 32'h0000_4444, 16'h0300, 16'h0042);
        run_case(0, 1, 1, 1, 8'h00, 8'h22, 32'h0000_2000, 32'h0000_9000, 32'h0000_5554, 16'h0100, 16'h0010);
        run_case(0, 0, 1, 1, 8'h00, 8'hFF, 32'hFFFF_FC00, 32'h0000_0008, 32'h1234_5678, 16'h03FF, 16'hFFFF);
        run_case(0, 0, 1, 0, 8'h00, 8'h33, 32'h0000_3000, 32'h0000_A000, 32'h0000_0000, 16'h0300, 16'h0000);
        run_case(1, 0, 1, 0, 8'h00, 8'h33, 32'h0000_3000, 32'h0000_0004, 32'hFFFF_FFFC, 16'hFFFF, 16'h8001);

        // No acceptance without a boundary.
        trap_req = 1'b1; nmi_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!busy, "R2 no boundary no entry", 32'(busy), 32'd0);
        end
        drop_reqs();

        // Requests while busy are ignored.
        begin
            int p0;
            #1;
            p0 = psr_n;
            trap_req = 1'b1; trap_vec = 8'h09; psr_in = 16'h0B00; boundary = 1'b1;
            isp_in = 32'h0000_6000; intbase_in = 32'h0000_0400;
            @(negedge clk);
            trap_req = 1'b0; nmi_req = 1'b1; int_req = 1'b1;
            wait_done();
            chk(exc_kind == 2'd1, "R9 kind kept under new requests", 32'(exc_kind), 32'd1);
            drop_reqs();
            repeat (2) begin
                @(negedge clk);
                chk(!busy, "R9 no re-entry", 32'(busy), 32'd0);
            end
            #1;
            chk(psr_n == p0 + 1, "R9 single status update", 32'(psr_n - p0), 32'd1);
        end

        // Random mix.
        for (int c = 0; c < 40; c++) begin
            run_case(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
                     ($urandom % 4) != 0, 8'($urandom), 8'($urandom),
                     $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, $urandom,
                     16'($urandom), 16'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

endmodule